// File: doc/BRIEF.md
# DRAM Strobe-Order Cycle Decoder

This block is the device side of a one-bit-wide dynamic memory whose row strobe, column strobe and write strobe are sampled on a system clock. It works out what each period of row strobe low means from the order in which the strobes move. If the column strobe is already low when the row strobe falls, the cycle is a refresh that takes its row from an internal counter. If the row strobe pulses with the column strobe held high throughout, the cycle refreshes the row given on the address pins. Every other row-strobe-low period is an access cycle. In an access cycle the row is captured when the row strobe falls and a column is captured on each fall of the column strobe.

Access cycles support early write, plain read, read-modify-write and page mode, which is several column pulses within one row. Each access reads or writes a small internal array that the parameters size. The data output has an enable for the tri-state pad. The enable is asserted only while read data is valid, and it stays asserted through a hidden refresh. In a hidden refresh the column strobe is held low from a read while the row strobe pulses again. A refresh with the write strobe low turns on a test-mode flag. The next refresh of either kind that is not a test-mode entry turns it off. Each refresh is reported for one cycle together with the row it covers.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset the output enable, the test-mode flag and the refresh pulse are low, and the first counter refresh covers row 0.
- R2: In an access cycle, the row is the address present in the cycle where the row strobe is first seen low. The array cell used is the low row bits joined with the low bits of the address present when the column strobe falls. Later changes on the pins do not change the row.
- R3: If the write strobe is low when the column strobe falls in an access cycle, din is stored at the selected cell and the output enable stays low for the whole cycle.
- R4: If the write strobe is high when the column strobe falls in an access cycle, the next cycle shows dout equal to the stored bit with the output enable high. The enable goes low in the cycle after the column strobe rises.
- R5: Page mode: several column pulses within one row-strobe-low period each read or write a different column of the same captured row.
- R6: Read-modify-write: if the write strobe falls while the column strobe is low in a read, din is stored at that column, and dout keeps showing the previously read bit until the column strobe rises.
- R7: A row-strobe fall with the column strobe low is a counter refresh. rfsh_valid pulses in the next cycle with rfsh_row equal to the counter, the address pins are ignored, and the output enable is not turned on.
- R8: The refresh counter steps by one after each counter refresh and wraps from 2^ADDR_W-1 to 0. Access cycles and row-only refreshes do not move it.
- R9: A row-strobe low period with no column fall is a row-only refresh. At the row-strobe rise, rfsh_valid pulses with rfsh_row equal to the captured row address, and the output stays disabled.
- R10: A counter refresh entered with the write strobe low sets test_mode. A counter refresh with the write strobe high, or a row-only refresh, clears it. Access cycles leave it unchanged.
- R11: Hidden refresh: if the column strobe is held low from a read while the row strobe rises and falls again, a counter refresh is performed, and dout and the output enable stay unchanged until the column strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data |
| dout_oe | output | 1 | Output driver enable (low means high impedance) |
| test_mode | output | 1 | Test-mode flag |
| rfsh_valid | output | 1 | One-cycle pulse marking a completed refresh decode |
| rfsh_row | output | ADDR_W | Row covered by that refresh |

## Verification
The bench uses the default parameters: a 10-bit address and a 16-by-16 array. The array is small enough that every cell can be written and then read back, with the expected bit computed from its row and column. The 10-bit counter is short enough that more than 1024 counter refreshes run the count through its wrap back to zero. Hidden, row-only, read-modify-write, page-mode and test-mode sequences are placed between the refreshes, so the expected counter value also confirms that these cycles do not move it.

// File: rtl/dram_dec_pkg.sv
// Shared types for the strobe-order cycle decoder.
package dram_dec_pkg;
    // Kind of the current row-strobe-low period
    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ACCESS  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_kind_t;

    // Bit positions inside the sampled strobe vector
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_N   = 3;
endpackage

// File: rtl/dram_strobe_edges.sv
// Edge detector for the sampled strobes.
// Keeps the previous sample of each strobe and flags falls and rises as
// combinational pulses valid in the cycle the new level is present.
// Assumes the strobes are already synchronous to clk.
module dram_strobe_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // Remember last sample; strobes are inactive-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    // Edge pulses from previous and current level
    always_comb begin
        fall_o = prev_q & ~lvl_i;
        rise_o = ~prev_q & lvl_i;
    end
endmodule

// File: rtl/dram_refresh_ctr.sv
// Internal refresh row counter.
// Steps once per counter refresh and wraps naturally at 2^W.
module dram_refresh_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Count refreshes, wrap by overflow
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R8
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/dram_cell_array.sv
// One-bit-wide storage array with a single shared address.
// Write is synchronous; read is combinational so the controller can
// capture the bit on the same edge that latches the column.
// No reset: content is undefined until written.
module dram_cell_array #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic                         clk,
    input  logic                         we_i,
    input  logic [ROW_BITS+COL_BITS-1:0] idx_i,
    input  logic                         wd_i,
    output logic                         rd_o
);
    localparam int DEPTH = 1 << (ROW_BITS + COL_BITS);

    logic [DEPTH-1:0] cells_q;

    // Store one bit on write
    always_ff @(posedge clk) begin
        if (we_i) cells_q[idx_i] <= wd_i;
    end

    assign rd_o = cells_q[idx_i];
endmodule

// File: rtl/dram_cycle_ctrl.sv
// Cycle decoder and access controller.
// Classifies each row-strobe-low period from the strobe order, latches
// row and column, drives array writes, read data, output enable, the
// test-mode flag and the refresh report.
// Assumes edge pulses come from dram_strobe_edges on the same samples.
module dram_cycle_ctrl
    import dram_dec_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ras_n_i,
    input  logic                         cas_n_i,
    input  logic                         we_n_i,
    input  logic                         ras_fall_i,
    input  logic                         ras_rise_i,
    input  logic                         cas_fall_i,
    input  logic                         cas_rise_i,
    input  logic                         we_fall_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         din_i,
    input  logic [ADDR_W-1:0]            ctr_i,
    output logic                         ctr_inc_o,
    output logic                         mem_we_o,
    output logic [ROW_BITS+COL_BITS-1:0] mem_idx_o,
    output logic                         mem_wd_o,
    input  logic                         mem_rd_i,
    output logic                         dout_o,
    output logic                         oe_o,
    output logic                         test_o,
    output logic                         rfsh_valid_o,
    output logic [ADDR_W-1:0]            rfsh_row_o
);
    cyc_kind_t         kind_q;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic              cas_seen_q;
    logic              rd_active_q;

    logic access_live;
    logic cas_access;
    logic rmw_write;
    logic [COL_BITS-1:0] col_sel;

    // Qualify column events against the decoded cycle kind
    always_comb begin
        access_live = (kind_q == CYC_ACCESS) && !ras_n_i;
        cas_access  = access_live && cas_fall_i;
        rmw_write   = access_live && rd_active_q && we_fall_i && !cas_n_i;
        col_sel     = cas_access ? addr_i[COL_BITS-1:0] : col_q[COL_BITS-1:0];
    end

    // Array and counter requests
    always_comb begin
        mem_we_o  = (cas_access && !we_n_i) || rmw_write;
        mem_idx_o = {row_q[ROW_BITS-1:0], col_sel};
        mem_wd_o  = din_i;
        ctr_inc_o = ras_fall_i && !cas_n_i;
    end

    // Cycle classification, latches, output and refresh report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q       <= CYC_IDLE;
            row_q        <= '0;
            col_q        <= '0;
            cas_seen_q   <= 1'b0;
            rd_active_q  <= 1'b0;
            dout_o       <= 1'b0;
            oe_o         <= 1'b0;
            test_o       <= 1'b0;
            rfsh_valid_o <= 1'b0;
            rfsh_row_o   <= '0;
        end else begin
            rfsh_valid_o <= 1'b0;
            if (ras_fall_i) begin
                if (cas_n_i) begin
                    kind_q     <= CYC_ACCESS;
                    row_q      <= addr_i;
                    cas_seen_q <= 1'b0;
                end else begin
                    kind_q       <= CYC_REFRESH;
                    rfsh_valid_o <= 1'b1;
                    rfsh_row_o   <= ctr_i;
                    test_o       <= !we_n_i;
                end
            end else if (ras_rise_i) begin
                if (kind_q == CYC_ACCESS && !cas_seen_q) begin
                    rfsh_valid_o <= 1'b1;
                    rfsh_row_o   <= row_q;
                    test_o       <= 1'b0;
                end
                kind_q <= CYC_IDLE;
            end
            if (cas_access) begin
                cas_seen_q <= 1'b1;
                col_q      <= addr_i;
                if (we_n_i) begin
                    rd_active_q <= 1'b1;
                    oe_o        <= 1'b1;
                    dout_o      <= mem_rd_i;
                end else begin
                    rd_active_q <= 1'b0;
                end
            end
            if (cas_rise_i) begin
                oe_o        <= 1'b0;
                rd_active_q <= 1'b0;
            end
        end
    end

    // R3
    early_write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_access && !we_n_i) |=> !oe_o);
    // R4
    cas_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_rise_i |=> !oe_o);
    // R7
    cbr_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall_i && !cas_n_i) |=> (rfsh_valid_o && rfsh_row_o == $past(ctr_i)));
    // R10
    test_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall_i && !cas_n_i && !we_n_i) |=> test_o);
    // R11
    hidden_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall_i && !cas_n_i && oe_o && !cas_rise_i) |=> oe_o);
endmodule

// File: rtl/dram_cycle_decoder.sv
// Top of the strobe-order cycle decoder.
// Wires edge detection, cycle control, refresh counter and storage.
// Assumes strobes and address are synchronous to clk.
module dram_cycle_decoder #(
    parameter int ADDR_W   = 10,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic              test_mode,
    output logic              rfsh_valid,
    output logic [ADDR_W-1:0] rfsh_row
);
    import dram_dec_pkg::*;

    localparam int IDX_W = ROW_BITS + COL_BITS;

    logic [STB_N-1:0] stb_lvl, stb_fall, stb_rise;
    logic             ctr_inc, mem_we, mem_wd, mem_rd;
    logic [ADDR_W-1:0] ctr_val;
    logic [IDX_W-1:0]  mem_idx;

    // Pack strobes in package bit order
    always_comb begin
        stb_lvl          = '1;
        stb_lvl[STB_RAS] = ras_n;
        stb_lvl[STB_CAS] = cas_n;
        stb_lvl[STB_WE]  = we_n;
    end

    dram_strobe_edges #(.N(STB_N)) i_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (stb_lvl),
        .fall_o (stb_fall),
        .rise_o (stb_rise)
    );

    dram_refresh_ctr #(.W(ADDR_W)) i_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (ctr_inc),
        .cnt_o (ctr_val)
    );

    dram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_cells (
        .clk   (clk),
        .we_i  (mem_we),
        .idx_i (mem_idx),
        .wd_i  (mem_wd),
        .rd_o  (mem_rd)
    );

    dram_cycle_ctrl #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ras_n_i      (ras_n),
        .cas_n_i      (cas_n),
        .we_n_i       (we_n),
        .ras_fall_i   (stb_fall[STB_RAS]),
        .ras_rise_i   (stb_rise[STB_RAS]),
        .cas_fall_i   (stb_fall[STB_CAS]),
        .cas_rise_i   (stb_rise[STB_CAS]),
        .we_fall_i    (stb_fall[STB_WE]),
        .addr_i       (addr),
        .din_i        (din),
        .ctr_i        (ctr_val),
        .ctr_inc_o    (ctr_inc),
        .mem_we_o     (mem_we),
        .mem_idx_o    (mem_idx),
        .mem_wd_o     (mem_wd),
        .mem_rd_i     (mem_rd),
        .dout_o       (dout),
        .oe_o         (dout_oe),
        .test_o       (test_mode),
        .rfsh_valid_o (rfsh_valid),
        .rfsh_row_o   (rfsh_row)
    );

    // R9
    rfsh_idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_valid && !$past(dout_oe)) |-> !dout_oe);
endmodule

// File: tb/test_dram_cycle_decoder.sv
module test_dram_cycle_decoder;
    localparam int AW = 10;
    localparam int RB = 4;
    localparam int CB = 4;
    localparam int ROWS = 1 << RB;
    localparam int COLS = 1 << CB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [AW-1:0] addr = '0;
    logic dout, dout_oe, test_mode, rfsh_valid;
    logic [AW-1:0] rfsh_row;

    int n_run = 0;
    int n_fail = 0;
    int exp_ctr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dram_cycle_decoder #(.ADDR_W(AW), .ROW_BITS(RB), .COL_BITS(CB)) i_dram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .test_mode(test_mode), .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row)
    );

    function automatic logic pat(int r, int c, int s);
        return ((r * 5 + c * 3 + s) % 3) == 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cell(int r, int c, logic d);
        addr = AW'(r); ras_n = 1'b0; tick();
        addr = AW'(c); we_n = 1'b0; din = d; cas_n = 1'b0; tick();
        chk(dout_oe == 1'b0, "R3 oe low at early write", int'(dout_oe), 0);
        cas_n = 1'b1; we_n = 1'b1; tick();
        chk(dout_oe == 1'b0, "R3 oe low after write", int'(dout_oe), 0);
        ras_n = 1'b1; tick();
        chk(rfsh_valid == 1'b0, "R9 no refresh after access", int'(rfsh_valid), 0);
    endtask

    task automatic rd_cell(int r, int c, logic e);
        addr = AW'(r); ras_n = 1'b0; tick();
        addr = AW'(c); cas_n = 1'b0; tick();
        chk(dout_oe == 1'b1, "R4 oe on read", int'(dout_oe), 1);
        chk(dout == e, "R2 R4 read data", int'(dout), int'(e));
        cas_n = 1'b1; tick();
        chk(dout_oe == 1'b0, "R4 oe off after cas rise", int'(dout_oe), 0);
        ras_n = 1'b1; tick();
    endtask

    task automatic cbr(logic w, int junk);
        cas_n = 1'b0; tick();
        we_n = w; addr = AW'(junk); ras_n = 1'b0; tick();
        chk(rfsh_valid == 1'b1, "R7 refresh pulse", int'(rfsh_valid), 1);
        chk(int'(rfsh_row) == exp_ctr, "R7 R8 counter row", int'(rfsh_row), exp_ctr);
        chk(dout_oe == 1'b0, "R7 oe off", int'(dout_oe), 0);
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        we_n = 1'b1; ras_n = 1'b1; tick();
        cas_n = 1'b1; tick();
    endtask

    task automatic ras_only(int r);
        addr = AW'(r); ras_n = 1'b0; tick();
        chk(rfsh_valid == 1'b0, "R9 no pulse at fall", int'(rfsh_valid), 0);
        addr = AW'(~r); ras_n = 1'b1; tick();
        chk(rfsh_valid == 1'b1, "R9 pulse at rise", int'(rfsh_valid), 1);
        chk(int'(rfsh_row) == r, "R9 row", int'(rfsh_row), r);
        chk(dout_oe == 1'b0, "R9 oe off", int'(dout_oe), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic old;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        // R1 reset state
        chk(dout_oe == 1'b0, "R1 oe", int'(dout_oe), 0);
        chk(test_mode == 1'b0, "R1 test", int'(test_mode), 0);
        chk(rfsh_valid == 1'b0, "R1 pulse", int'(rfsh_valid), 0);
        cbr(1'b1, 333);  // R1 first row 0

        // R2 R3 R4 full sweep
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) wr_cell(r + 16 * (c % 4), c, pat(r, c, 0));
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) rd_cell(r, c + 16 * (r % 3), pat(r, c, 0));

        // R5 page write then page read on row 2
        addr = AW'(2); ras_n = 1'b0; tick();
        for (int c = 0; c < COLS; c++) begin
            addr = AW'(c); we_n = 1'b0; din = pat(2, c, 1); cas_n = 1'b0; tick();
            cas_n = 1'b1; we_n = 1'b1; tick();
        end
        ras_n = 1'b1; tick();
        addr = AW'(2); ras_n = 1'b0; tick();
        for (int c = 0; c < COLS; c++) begin
            addr = AW'(c); cas_n = 1'b0; tick();
            chk(dout == pat(2, c, 1) && dout_oe, "R5 page read", int'(dout), int'(pat(2, c, 1)));
            cas_n = 1'b1; tick();
        end
        ras_n = 1'b1; tick();
        rd_cell(3, 5, pat(3, 5, 0));  // R5 other rows untouched

        // R6 read-modify-write
        old = pat(9, 4, 0);
        addr = AW'(9); ras_n = 1'b0; tick();
        addr = AW'(4); cas_n = 1'b0; tick();
        chk(dout == old, "R6 read before modify", int'(dout), int'(old));
        din = ~old; we_n = 1'b0; tick();
        chk(dout == old && dout_oe, "R6 dout holds old", int'(dout), int'(old));
        cas_n = 1'b1; we_n = 1'b1; tick();
        ras_n = 1'b1; tick();
        rd_cell(9, 4, ~old);

        // R9 R8 row-only refresh leaves counter alone
        ras_only(777);
        ras_only(5);
        cbr(1'b1, 1);

        // R10 test mode entry and exits
        cbr(1'b0, 2);
        chk(test_mode == 1'b1, "R10 entry", int'(test_mode), 1);
        rd_cell(1, 1, pat(1, 1, 0));
        chk(test_mode == 1'b1, "R10 access keeps", int'(test_mode), 1);
        cbr(1'b1, 3);
        chk(test_mode == 1'b0, "R10 exit by plain refresh", int'(test_mode), 0);
        cbr(1'b0, 4);
        chk(test_mode == 1'b1, "R10 re-entry", int'(test_mode), 1);
        ras_only(12);
        chk(test_mode == 1'b0, "R10 exit by row-only", int'(test_mode), 0);

        // R11 hidden refresh
        addr = AW'(3); ras_n = 1'b0; tick();
        addr = AW'(7); cas_n = 1'b0; tick();
        chk(dout == pat(3, 7, 0), "R11 first read", int'(dout), int'(pat(3, 7, 0)));
        ras_n = 1'b1; tick();
        chk(dout_oe == 1'b1, "R11 oe during ras high", int'(dout_oe), 1);
        addr = AW'(999); ras_n = 1'b0; tick();
        chk(rfsh_valid == 1'b1, "R11 refresh pulse", int'(rfsh_valid), 1);
        chk(int'(rfsh_row) == exp_ctr, "R11 counter row", int'(rfsh_row), exp_ctr);
        chk(dout_oe == 1'b1 && dout == pat(3, 7, 0), "R11 data held", int'(dout), int'(pat(3, 7, 0)));
        exp_ctr = (exp_ctr + 1) % (1 << AW);
        ras_n = 1'b1; tick();
        chk(dout_oe == 1'b1, "R11 held after ras rise", int'(dout_oe), 1);
        cas_n = 1'b1; tick();
        chk(dout_oe == 1'b0, "R11 off after cas rise", int'(dout_oe), 0);

        // R8 wrap through the whole counter range
        for (int i = 0; i < (1 << AW) + 8; i++) cbr(1'b1, i);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule